// File: doc/BRIEF.md
# Stop-Marked Bundle Issue Grouper

The grouper sits between instruction fetch and dispatch in a wide in-order core whose compiler marks parallelism explicitly. Fetch delivers 128-bit bundles, each packing three fixed-length instruction slots and a small template. Three template bits are stop marks, one after each slot. A set mark ends the current issue group at that point. A clear mark lets the group continue, including into the next bundle. This means a parallel group can be any length, while the block emits it in pieces no wider than the issue width.

Each emitted lane carries the predicate, the two source register numbers, the destination register number and the opcode bits. These fields are already split out, so dispatch never parses raw slot bits. Opcode bits pass through untouched.

Both data edges use valid/ready. A bundle transfers on a clock edge where `in_valid` and `in_ready` are both high. A group transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value. The block also stops accepting bundles once it cannot make progress. Internally one slot is placed per cycle, so one bundle is taken at most every three cycles.

Top module: `bundle_issue_grouper`

## Requirements
- R1: A bundle holds the template in bits [4:0] and slot k (k = 0, 1, 2) in bits [41k+45 : 41k+5]. Slot 0 is the oldest instruction.
- R2: Within a 41-bit slot, the fields are: predicate [5:0], destination register [12:6], source 2 register [19:13], source 1 register [26:20], opcode [40:27]. Lane i of the output carries these fields in out_pred[6i+5:6i], out_dst[7i+6:7i], out_src2[7i+6:7i], out_src1[7i+6:7i] and out_opc[14i+13:14i].
- R3: Template bit k set means a stop after slot k. The group is closed after that slot and emitted with its slots in program order: lane 0 holds the oldest slot, and out_count holds the number of slots.
- R4: A group with no stop after the last slot of a bundle stays open. It continues with slot 0 of the next accepted bundle.
- R5: A group that reaches 6 slots is closed and emitted even without a stop. The following slot starts a new group.
- R6: Template bits [4:3] have no effect on grouping or on any output.
- R7: While out_valid is high and out_ready is low, all outputs hold. No slot is lost or duplicated under any pattern of out_ready. in_ready goes low while the held bundle cannot advance.
- R8: Reset discards any partly built group and any held bundle. After reset, out_valid is low and in_ready is high. No group is emitted until a bundle has been accepted after reset.
- R9: While out_valid is high, out_count is between 1 and 6. Every lane at or above out_count reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The block takes the offered bundle at this edge |
| in_bundle | input | 128 | Bundle: three slots and a template |
| out_valid | output | 1 | An issue group is presented |
| out_ready | input | 1 | Downstream takes the group at this edge |
| out_count | output | 3 | Number of slots in the group (1 to 6) |
| out_pred | output | 36 | Predicate field per lane, 6 bits each |
| out_src1 | output | 42 | Source 1 register per lane, 7 bits each |
| out_src2 | output | 42 | Source 2 register per lane, 7 bits each |
| out_dst | output | 42 | Destination register per lane, 7 bits each |
| out_opc | output | 84 | Opcode bits per lane, 14 bits each |

## Verification
The bench drives groups that span two and three bundles. A design that closed groups at bundle edges would emit short groups and break the lane order. It feeds runs with no stops, so the 6-slot cap is hit both alone and in the same slot as a stop. Missing the cap would overflow the lane array, and double-counting would emit a spurious empty or single group. Random and long-held back-pressure expose a design that drops or repeats a slot, or one that moves data while stalled. A reset in the middle of an open group catches leftover slots leaking into the first group after reset. Bundles with the upper template bits set show whether those bits wrongly act as stops.

// File: rtl/bgrp_pkg.sv
package bgrp_pkg;
  localparam int BUNDLE_W = 128;
  localparam int SLOTS    = 3;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = BUNDLE_W - SLOTS * SLOT_W;
  localparam int PRED_W   = 6;
  localparam int REG_W    = 7;
  localparam int OPC_W    = SLOT_W - PRED_W - 3 * REG_W;
  localparam int IDX_W    = $clog2(SLOTS);

  localparam int PRED_LSB = 0;
  localparam int DST_LSB  = PRED_LSB + PRED_W;
  localparam int SRC2_LSB = DST_LSB + REG_W;
  localparam int SRC1_LSB = SRC2_LSB + REG_W;
  localparam int OPC_LSB  = SRC1_LSB + REG_W;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  src1;
    logic [REG_W-1:0]  src2;
    logic [REG_W-1:0]  dst;
    logic [PRED_W-1:0] pred;
  } slot_t;
endpackage

// File: rtl/bgrp_slot_decode.sv
module bgrp_slot_decode
  import bgrp_pkg::*;
(
  input  logic [SLOT_W-1:0] raw,
  output slot_t             fields
);
  always_comb begin
    fields.pred = raw[PRED_LSB +: PRED_W];
    fields.dst  = raw[DST_LSB  +: REG_W];
    fields.src2 = raw[SRC2_LSB +: REG_W];
    fields.src1 = raw[SRC1_LSB +: REG_W];
    fields.opc  = raw[OPC_LSB  +: OPC_W];
  end
endmodule

// File: rtl/bgrp_stage.sv
module bgrp_stage
  import bgrp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BUNDLE_W-1:0] in_bundle,
  input  logic                take,
  output logic                cur_valid,
  output slot_t               cur_slot,
  output logic                cur_stop
);
  slot_t             dec  [SLOTS];
  slot_t             held [SLOTS];
  logic [SLOTS-1:0]  held_stop;
  logic              hold_v;
  logic [IDX_W-1:0]  idx;
  logic              last;
  logic              accept;
  logic              unused_tmpl_hi;

  for (genvar k = 0; k < SLOTS; k++) begin : g_dec
    bgrp_slot_decode u_dec (
      .raw    (in_bundle[TMPL_W + k*SLOT_W +: SLOT_W]),
      .fields (dec[k])
    );
  end

  assign unused_tmpl_hi = ^in_bundle[TMPL_W-1:SLOTS];

  assign last     = (idx == IDX_W'(SLOTS-1));
  assign in_ready = !hold_v || (take && last);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      idx    <= '0;
    end else if (accept) begin
      hold_v <= 1'b1;
      idx    <= '0;
    end else if (take) begin
      if (last) hold_v <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      held      <= dec;
      held_stop <= in_bundle[SLOTS-1:0];
    end
  end

  assign cur_valid = hold_v;
  assign cur_slot  = held[idx];
  assign cur_stop  = held_stop[idx];
endmodule

// File: rtl/bgrp_accum.sv
module bgrp_accum
  import bgrp_pkg::*;
#(
  parameter  int GRP_MAX = 6,
  localparam int CNT_W   = $clog2(GRP_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cur_valid,
  input  slot_t                      cur_slot,
  input  logic                       cur_stop,
  output logic                       take,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [CNT_W-1:0]           out_count,
  output slot_t [GRP_MAX-1:0]        out_slots
);
  slot_t            acc [GRP_MAX];
  logic [CNT_W-1:0] cnt;
  logic             close;
  logic             out_free;

  assign close    = cur_stop || (cnt == CNT_W'(GRP_MAX-1));
  assign out_free = !out_valid || out_ready;
  assign take     = cur_valid && (!close || out_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_slots <= '0;
      cnt       <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (close) begin
          out_valid <= 1'b1;
          out_count <= cnt + 1'b1;
          for (int i = 0; i < GRP_MAX; i++) begin
            if (CNT_W'(i) < cnt)       out_slots[i] <= acc[i];
            else if (CNT_W'(i) == cnt) out_slots[i] <= cur_slot;
            else                       out_slots[i] <= '0;
          end
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && !close) acc[cnt] <= cur_slot;
  end
endmodule

// File: rtl/bundle_issue_grouper.sv
module bundle_issue_grouper
  import bgrp_pkg::*;
#(
  parameter  int GRP_MAX = 6,
  localparam int CNT_W   = $clog2(GRP_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [BUNDLE_W-1:0]         in_bundle,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [CNT_W-1:0]            out_count,
  output logic [GRP_MAX*PRED_W-1:0]   out_pred,
  output logic [GRP_MAX*REG_W-1:0]    out_src1,
  output logic [GRP_MAX*REG_W-1:0]    out_src2,
  output logic [GRP_MAX*REG_W-1:0]    out_dst,
  output logic [GRP_MAX*OPC_W-1:0]    out_opc
);
  logic                 cur_valid;
  slot_t                cur_slot;
  logic                 cur_stop;
  logic                 take;
  slot_t [GRP_MAX-1:0]  lanes;

  bgrp_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bundle (in_bundle),
    .take      (take),
    .cur_valid (cur_valid),
    .cur_slot  (cur_slot),
    .cur_stop  (cur_stop)
  );

  bgrp_accum #(.GRP_MAX(GRP_MAX)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .cur_valid (cur_valid),
    .cur_slot  (cur_slot),
    .cur_stop  (cur_stop),
    .take      (take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_count (out_count),
    .out_slots (lanes)
  );

  for (genvar i = 0; i < GRP_MAX; i++) begin : g_lane
    assign out_pred[i*PRED_W +: PRED_W] = lanes[i].pred;
    assign out_src1[i*REG_W  +: REG_W]  = lanes[i].src1;
    assign out_src2[i*REG_W  +: REG_W]  = lanes[i].src2;
    assign out_dst [i*REG_W  +: REG_W]  = lanes[i].dst;
    assign out_opc [i*OPC_W  +: OPC_W]  = lanes[i].opc;
  end
endmodule

// File: rtl/bgrp_checker.sv
module bgrp_checker
  import bgrp_pkg::*;
#(
  parameter  int GRP_MAX = 6,
  localparam int CNT_W   = $clog2(GRP_MAX + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [CNT_W-1:0]            out_count,
  input logic [GRP_MAX*PRED_W-1:0]   out_pred,
  input logic [GRP_MAX*REG_W-1:0]    out_src1,
  input logic [GRP_MAX*REG_W-1:0]    out_src2,
  input logic [GRP_MAX*REG_W-1:0]    out_dst,
  input logic [GRP_MAX*OPC_W-1:0]    out_opc
);
  logic seen_bundle;

  always_ff @(posedge clk) begin
    if (rst)                        seen_bundle <= 1'b0;
    else if (in_valid && in_ready)  seen_bundle <= 1'b1;
  end

  // R7: a stalled group holds every output
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count) &&
      $stable(out_pred) && $stable(out_src1) && $stable(out_src2) &&
      $stable(out_dst) && $stable(out_opc)));

  // R8: nothing is emitted before a bundle is accepted after reset
  a_r8_no_early_group: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_bundle);

  // R5 / R9: group size stays within 1..GRP_MAX
  a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count >= CNT_W'(1) && out_count <= CNT_W'(GRP_MAX)));

  for (genvar i = 0; i < GRP_MAX; i++) begin : g_idle
    // R9: lanes past the group size are zero
    a_r9_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_count <= CNT_W'(i)) |->
        (out_pred[i*PRED_W +: PRED_W] == '0 && out_src1[i*REG_W +: REG_W] == '0 &&
         out_src2[i*REG_W +: REG_W] == '0 && out_dst[i*REG_W +: REG_W] == '0 &&
         out_opc[i*OPC_W +: OPC_W] == '0));
  end
endmodule

bind bundle_issue_grouper bgrp_checker #(.GRP_MAX(GRP_MAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_count (out_count),
  .out_pred  (out_pred),
  .out_src1  (out_src1),
  .out_src2  (out_src2),
  .out_dst   (out_dst),
  .out_opc   (out_opc)
);

// File: tb/tb_bundle_issue_grouper.sv
module tb_bundle_issue_grouper;
  localparam int GM = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_bundle;
  logic         out_valid;
  logic         out_ready;
  logic [2:0]   out_count;
  logic [35:0]  out_pred;
  logic [41:0]  out_src1, out_src2, out_dst;
  logic [83:0]  out_opc;

  always #4 clk = ~clk;

  bundle_issue_grouper dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_pred(out_pred), .out_src1(out_src1),
    .out_src2(out_src2), .out_dst(out_dst), .out_opc(out_opc)
  );

  int    nvec = 0;
  int    nerr = 0;
  int    seq  = 1;
  int    rmode = 0;
  string cur_tag = "R8";

  logic [245:0] q_raw [$];
  int           q_n   [$];
  string        q_tag [$];
  logic [40:0]  m_acc [GM];
  int           m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // reference grouping taken from R3, R4, R5 (template bit k = stop after slot k)
  task automatic model_slot(input logic [40:0] r, input logic stp);
    logic [245:0] flat;
    m_acc[m_cnt] = r;
    m_cnt++;
    if (stp || m_cnt == GM) begin
      flat = '0;
      for (int i = 0; i < m_cnt; i++) flat[i*41 +: 41] = m_acc[i];
      q_raw.push_back(flat);
      q_n.push_back(m_cnt);
      q_tag.push_back(cur_tag);
      m_cnt = 0;
    end
  endtask

  function automatic logic [40:0] mk_slot(input int k);
    return {14'(k*613 + 5), 7'(k*3 + 1), 7'(k*5 + 2), 7'(k*11 + 3), 6'(k)};
  endfunction

  // R1: slot k at [41k+45:41k+5], template at [4:0]
  task automatic send(input logic [4:0] tmpl);
    logic [127:0] b;
    bit acc;
    b = {mk_slot(seq + 2), mk_slot(seq + 1), mk_slot(seq), tmpl};
    seq += 3;
    for (int k = 0; k < 3; k++) model_slot(b[5 + 41*k +: 41], b[k]);
    in_bundle = b;
    in_valid  = 1'b1;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && q_n.size() != 0; i++) @(posedge clk);
    #1;
  endtask

  // out_ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (rmode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom_range(0, 1));
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    logic [245:0] flat;
    logic [40:0]  r;
    logic [35:0]  ep;
    logic [41:0]  es1, es2, ed;
    logic [83:0]  eo;
    int           n;
    string        tg;
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        if (q_n.size() == 0) begin
          chk(1'b0, "R8", $sformatf("group of %0d emitted, expected none", out_count));
        end else begin
          flat = q_raw.pop_front();
          n    = q_n.pop_front();
          tg   = q_tag.pop_front();
          ep = '0; es1 = '0; es2 = '0; ed = '0; eo = '0;
          for (int i = 0; i < n; i++) begin
            r = flat[i*41 +: 41];
            ep[i*6 +: 6]   = r[5:0];
            ed[i*7 +: 7]   = r[12:6];
            es2[i*7 +: 7]  = r[19:13];
            es1[i*7 +: 7]  = r[26:20];
            eo[i*14 +: 14] = r[40:27];
          end
          chk(out_count == 3'(n) && out_pred == ep && out_src1 == es1 &&
              out_src2 == es2 && out_dst == ed && out_opc == eo, tg,
              $sformatf("count %0d exp %0d pred %h exp %h src1 %h exp %h src2 %h exp %h dst %h exp %h opc %h exp %h",
                        out_count, n, out_pred, ep, out_src1, es1, out_src2, es2,
                        out_dst, ed, out_opc, eo));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nvec++;
    $display("FAIL watchdog: run hung, actual not finished, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bundle = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R8: reset state
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8",
        $sformatf("out_valid %b in_ready %b exp 0 1", out_valid, in_ready));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R8", $sformatf("out_valid %b exp 0 before any bundle", out_valid));
    end
    @(posedge clk); #1;

    // R1 / R2: stop after every slot, one-slot groups
    cur_tag = "R1"; send(5'b00111);
    cur_tag = "R2"; send(5'b00111);
    drain();

    // R3: stop after slot 1 only, then R4 spanning groups
    cur_tag = "R3"; send(5'b00010);
    cur_tag = "R4"; send(5'b00001);
    send(5'b00100);
    drain();

    // R5: cap at six slots, alone and coinciding with a stop
    cur_tag = "R5";
    send(5'b00000); send(5'b00000); send(5'b00000); send(5'b00100);
    send(5'b00000); send(5'b00000); send(5'b00001); send(5'b00110);
    drain();

    // R6: upper template bits have no effect
    cur_tag = "R6";
    send(5'b11000); send(5'b01010); send(5'b10001); send(5'b11100);
    drain();

    // R7: random back-pressure and random templates
    cur_tag = "R7";
    rmode = 1;
    for (int i = 0; i < 40; i++) send(5'($urandom_range(0, 31)));
    send(5'b00100);
    rmode = 0;
    drain();

    // R7: long stall, input must be held off
    rmode = 2;
    @(posedge clk); #1;
    fork
      begin
        send(5'b00111);
        send(5'b00111);
      end
      begin
        for (int i = 0; i < 12; i++) @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b1, "R7",
            $sformatf("in_ready %b out_valid %b exp 0 1 while stalled", in_ready, out_valid));
        rmode = 0;
      end
    join
    drain();

    // R8: reset in the middle of an open group
    cur_tag = "R8";
    send(5'b00000);
    repeat (5) @(posedge clk);
    #1 rst = 1'b1;
    m_cnt = 0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!out_valid && in_ready, "R8",
          $sformatf("out_valid %b in_ready %b exp 0 1 after reset", out_valid, in_ready));
    end
    @(posedge clk); #1;
    send(5'b00100);
    drain();

    chk(q_n.size() == 0, "R7", $sformatf("%0d groups missing, exp 0", q_n.size()));
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule